// File: doc/BRIEF.md
# Selectable-Ratio Gated Clock Divider

This block derives a slower clock from a fast input clock by letting through only some of the input's high pulses. A two-bit ratio code N selects how often a pulse passes: one output pulse for every N+1 input periods. Code 0 passes the input clock through unchanged. Each output pulse has exactly the high time of the input pulse it came from. The duty cycle is therefore not 50 % for the higher ratios.

A phase counter advances on every rising edge of the input clock and wraps after it reaches the selected code. A gate-enable register samples whether the counter sits at the code. That register updates on the falling edge of the input clock, so the enable only moves while the input is low and the AND gate at the output cannot produce a glitch. An active-low reset clears both registers asynchronously. While reset is held, the output is low. The ratio code is meant to be set while reset is asserted and then held steady.

Top module: `gdiv_top`

## Requirements
- R1: With ratio code N (N = 0..3), consecutive rising edges of `clk_out` are exactly N+1 input periods apart. The phase counter counts 0, 1, …, N and then wraps to 0 on rising input edges.
- R2: Every `clk_out` pulse stays high for exactly the high time of one input pulse.
- R3: With code 0, once the first falling input edge after reset release has passed, `clk_out` is high whenever `clk_in` is high and low whenever `clk_in` is low.
- R4: `clk_out` is never high while `clk_in` is low.
- R5: While `rst_n` is low, `clk_out` is low and the phase counter is zero. Asserting `rst_n` forces `clk_out` low at once, without waiting for a clock edge.
- R6: When reset is released while `clk_in` is low, the first `clk_out` pulse comes on rising input edge N+1 for N ≥ 1, and on rising input edge 2 for N = 0.
- R7: The gate enable changes only at falling input edges. At every rising input edge it equals whether the phase counter held the selected code at the preceding falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_sel | input | RATIO_W (2) | Ratio code N; output rate is input rate / (N+1) |
| clk_out | output | 1 | Gated divided clock |

## Verification
A phase counter stuck or wrapping at the wrong value shows at the ports within one division period, because the spacing between output rising edges changes. The scoreboard reports it on the second output pulse. A gate enable taken from the wrong edge or the wrong comparison shows up as a widened pulse, a pulse during the low phase, or a missing pulse within one input period of the fault. A reset that is not truly asynchronous shows when reset is raised in the middle of a high phase and the output does not drop.

// File: rtl/gdiv_pkg.sv
`timescale 1ns/1ps
package gdiv_pkg;

    localparam int RATIO_W_DEF = 2;

    // Phase advance: wrap to zero once the selected code is reached.
    function automatic logic [RATIO_W_DEF-1:0] phase_advance(
        input logic [RATIO_W_DEF-1:0] cur,
        input logic [RATIO_W_DEF-1:0] code
    );
        if (cur == code) begin
            return '0;
        end
        return cur + 1'b1;
    endfunction

endpackage

// File: rtl/gdiv_phase_ctr.sv
`timescale 1ns/1ps
module gdiv_phase_ctr #(
    parameter int RATIO_W = gdiv_pkg::RATIO_W_DEF
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_sel,
    output logic [RATIO_W-1:0] phase_q,
    output logic               at_code
);
    logic [RATIO_W-1:0] phase_d;

    always_comb begin
        at_code = (phase_q == ratio_sel);
        phase_d = at_code ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end
endmodule

// File: rtl/gdiv_gate_reg.sv
`timescale 1ns/1ps
module gdiv_gate_reg (
    input  logic clk_in,
    input  logic rst_n,
    input  logic at_code,
    output logic gate_en
);
    // Updated on the falling edge so the enable is settled for the whole high phase.
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            gate_en <= 1'b0;
        end else begin
            gate_en <= at_code;
        end
    end
endmodule

// File: rtl/gdiv_clk_and.sv
`timescale 1ns/1ps
module gdiv_clk_and (
    input  logic clk_in,
    input  logic gate_en,
    output logic clk_out
);
    assign clk_out = clk_in & gate_en;
endmodule

// File: rtl/gdiv_top.sv
`timescale 1ns/1ps
module gdiv_top #(
    parameter int RATIO_W = gdiv_pkg::RATIO_W_DEF
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_sel,
    output logic               clk_out
);
    logic [RATIO_W-1:0] phase_q;
    logic               at_code;
    logic               gate_en;

    gdiv_phase_ctr #(.RATIO_W(RATIO_W)) u_phase (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .ratio_sel(ratio_sel),
        .phase_q  (phase_q),
        .at_code  (at_code)
    );

    gdiv_gate_reg u_gate (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .at_code(at_code),
        .gate_en(gate_en)
    );

    gdiv_clk_and u_and (
        .clk_in (clk_in),
        .gate_en(gate_en),
        .clk_out(clk_out)
    );
endmodule

// File: rtl/gdiv_chk.sv
`timescale 1ns/1ps
module gdiv_chk #(
    parameter int RATIO_W = 2
) (
    input logic               clk_in,
    input logic               rst_n,
    input logic [RATIO_W-1:0] ratio_sel,
    input logic [RATIO_W-1:0] phase,
    input logic               gate_en
);
    logic seen_fall;

    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            seen_fall <= 1'b0;
        end else begin
            seen_fall <= 1'b1;
        end
    end

    AST_PHASE_BOUND: assert property (@(posedge clk_in) disable iff (!rst_n)
        phase <= ratio_sel);                                              // R1
    AST_PHASE_WRAP: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase == ratio_sel) |=> (phase == '0));                           // R1
    AST_PHASE_STEP: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase != ratio_sel) |=> (phase == RATIO_W'($past(phase) + 1'b1)));  // R1
    AST_GATE_MATCH: assert property (@(posedge clk_in) disable iff (!rst_n)
        seen_fall |-> (gate_en == (phase == ratio_sel)));                  // R7
    AST_RELEASE_ZERO: assert property (@(posedge clk_in)
        $rose(rst_n) |-> (phase == '0));                                   // R5
endmodule

bind gdiv_top gdiv_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .ratio_sel(ratio_sel),
    .phase    (phase_q),
    .gate_en  (gate_en)
);

// File: tb/sim_gdiv_top.sv
`timescale 1ns/1ps
module sim_gdiv_top;
    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic [1:0] sel    = 2'd0;
    logic       clk_out;

    int  errors = 0;
    int  checks = 0;
    real exp_q[$];
    bit  armed = 0;
    bit  have_prev = 0;
    real last_rise = 0.0;

    gdiv_top u0 (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .ratio_sel(sel),
        .clk_out  (clk_out)
    );

    always #5 clk_in = ~clk_in;

    task automatic check(input bit ok, input string req, input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0.3f expected=%0.3f", req, $time, act, exp);
        end
    endtask

    // Monitor: pop expected spacing on each output rising edge (R1)
    always @(posedge clk_out) begin
        if (armed) begin
            if (have_prev && exp_q.size() > 0) begin
                real e;
                real a;
                e = exp_q.pop_front();
                a = $realtime - last_rise;
                check((a > e - 0.01) && (a < e + 0.01), "R1 spacing", a, e);
            end
            have_prev = 1;
            last_rise = $realtime;
        end
    end

    // Pulse high time equals input high time (R2)
    always @(negedge clk_out) begin
        if (armed && have_prev) begin
            real w;
            w = $realtime - last_rise;
            check((w > 4.99) && (w < 5.01), "R2 width", w, 5.0);
        end
    end

    // Output low during every input low phase (R4)
    always @(posedge clk_in) begin
        #7.5;
        if (rst_n) check(clk_out == 1'b0, "R4 low phase", real'(clk_out), 0.0);
    end

    task automatic run_code(input int c);
        int n;
        bit found;
        int guard;
        int expn;
        armed = 0;
        @(posedge clk_in); #7.5;
        rst_n = 1'b0;
        sel = 2'(c);
        @(posedge clk_in); #2.5;
        check(clk_out == 1'b0, "R5 held in reset", real'(clk_out), 0.0);
        #5;
        rst_n = 1'b1;
        have_prev = 0;
        armed = 1;
        n = 0;
        found = 0;
        for (int i = 0; i < 8 && !found; i++) begin
            @(posedge clk_in); #1;
            n++;
            if (clk_out) found = 1;
        end
        expn = (c == 0) ? 2 : c + 1;
        check(found && n == expn, "R6 first pulse edge", real'(n), real'(expn));
        for (int k = 0; k < 5; k++) exp_q.push_back(real'((c + 1) * 10));
        guard = 0;
        while (exp_q.size() > 0 && guard < 100) begin
            @(posedge clk_in);
            guard++;
        end
        check(exp_q.size() == 0, "R1 pulses seen", real'(exp_q.size()), 0.0);
        if (c == 0) begin
            for (int k = 0; k < 4; k++) begin
                @(posedge clk_in); #2.5;
                check(clk_out == 1'b1, "R3 pass high", real'(clk_out), 1.0);
                #5;
                check(clk_out == 1'b0, "R3 pass low", real'(clk_out), 0.0);
            end
        end
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            @(posedge clk_in); #2.5;
            check(clk_out == 1'b0, "R5 reset state", real'(clk_out), 0.0);
        end
        for (int c = 0; c < 4; c++) run_code(c);
        // Asynchronous reset in the middle of a high phase, code 0 (R5)
        run_code(0);
        armed = 0;
        @(posedge clk_in); #1;
        rst_n = 1'b0;
        #1.5;
        check(clk_out == 1'b0, "R5 async drop", real'(clk_out), 0.0);
        @(posedge clk_in); #2.5;
        check(clk_out == 1'b0, "R5 held after drop", real'(clk_out), 0.0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule